// File: doc/BRIEF.md
# Wired-OR Arbitration Competition Logic

Each module that takes part in a distributed backplane arbitration holds an 8-bit arbitration number and a parity bit. This block places that number onto a shared 9-line wired-OR bus, watches the bus, and works out whether it has won. Several copies of the block, one per module, share the same lines. Each line carries the OR of everything driven onto it.

Competition runs from the most significant bit down. A module stops driving its lower bits when the bus shows an asserted bit at a position where its own number has a 0. It drives those bits again if that bus bit clears. Across repeated bus updates the bus settles on the largest competing number. Only the winner is left driving the parity line.

The block reports three results:
- an active-low flag meaning "won" for a competing module, or "my number is greater than the winner's" for a module that only observes;
- a flag that is 1 when all eight competition bits are asserted;
- an active-low parity error flag for the nine received bits.

The bus side is inverting. An asserted line is a low level, and the block drives a line by pulling it low. The number is captured by an active-low latch enable. The receivers are gated by an active-low enable. A settle input tells the block that the bus has converged, and the win/greater result is only given while that input is high.

Top module: `arb_compete`

## Requirements
- R1: While `le_ni`=1 the number in use is `{num_par_i, num_i}` directly. While `le_ni`=0 the number in use is the one present at the last rising clock edge with `le_ni`=1. Reset clears the held number to zero.
- R2: The bus is inverting. `ab_pull_o[i]`=1 pulls line i low, which asserts it. `ab_level_i[i]`=0 means line i is asserted. Bits 7..0 are the competition bits and bit 8 is the parity line.
- R3: While `cmp_ni`=1 the module pulls no line: `ab_pull_o` = 0.
- R4: A competing module pulls competition line i only when its number has bit i set, and only while no higher line j is asserted at a position where its own bit j is 0. It pulls the parity line only when its parity bit is set and no line is asserted where its own bit is 0.
- R5: When the bus is resolved as the OR of all modules' pulls, once per clock, with unique numbers, the received competition bits equal the largest competing number within 9 updates. The received parity bit then equals that winner's parity bit. With no competitors, all 9 received bits are 0.
- R6: With `settle_i`=1, `rx_en_ni`=0 and `cmp_ni`=0, `win_no` is 0 exactly when the received competition bits equal the module's number.
- R7: With `settle_i`=1, `rx_en_ni`=0 and `cmp_ni`=1, `win_no` is 0 exactly when the module's number is greater than the received competition bits.
- R8: With `rx_en_ni`=0, `all_ones_o` is 1 exactly when all eight received competition lines are asserted.
- R9: With `rx_en_ni`=0, `par_err_no` is 0 exactly when the nine received bits hold an even number of asserted lines.
- R10: With `rx_en_ni`=1, the receivers are treated as seeing nothing asserted. In that state `all_ones_o`=0, `par_err_no`=1 and `win_no`=1, and a competing module pulls its full number and parity with no withdrawal.
- R11: While `settle_i`=0, `win_no`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the number latch |
| rst_ni | input | 1 | Asynchronous active-low reset |
| num_i | input | 8 | Local arbitration number |
| num_par_i | input | 1 | Parity bit captured with the number |
| le_ni | input | 1 | Latch enable, active low holds |
| cmp_ni | input | 1 | Compete enable, active low |
| rx_en_ni | input | 1 | Receiver enable, active low |
| settle_i | input | 1 | Bus converged, win/greater result valid |
| ab_level_i | input | 9 | Bus line levels, low = asserted |
| ab_pull_o | output | 9 | 1 = pull the matching bus line low |
| win_no | output | 1 | Active-low win or greater-than-winner |
| all_ones_o | output | 1 | All competition lines asserted |
| par_err_no | output | 1 | Active-low bus parity error |

## Verification
The assertions assume three things about the inputs:
- Arbitration numbers are unique among competitors, so a tie cannot happen.
- `settle_i` is raised only after the bus has been updated at least nine times with the numbers held steady.
- A number is held for a clock edge before the latch closes.

The stimulus meets these conditions in the following ways. It redraws any random number that repeats an earlier one, and it applies new numbers with the latch open for one edge. It holds `settle_i` low for twelve bus updates before sampling. It then scrambles the live number inputs after the latch closes, so the held copy alone decides the outcome.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned ARB_W_DEF = 8;

  typedef struct packed {
    logic all_ones;
    logic par_ok;
  } rx_flags_t;
endpackage

// File: rtl/arb_num_latch.sv
module arb_num_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         le_ni,
  input  logic [W-1:0] num_i,
  input  logic         par_i,
  output logic [W:0]   num_o
);
  logic [W:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_q <= '0;
    else if (le_ni) hold_q <= {par_i, num_i};
  end

  // open: pass-through; closed: last value seen open
  assign num_o = le_ni ? {par_i, num_i} : hold_q;
endmodule

// File: rtl/arb_rx.sv
module arb_rx #(
  parameter int unsigned W = 8
) (
  input  logic               rx_en_ni,
  input  logic [W:0]         level_i,
  output logic [W:0]         rx_o,
  output arb_pkg::rx_flags_t flags_o
);
  for (genvar i = 0; i <= W; i++) begin : g_rcv
    assign rx_o[i] = ~rx_en_ni & ~level_i[i];
  end

  assign flags_o.all_ones = ~rx_en_ni & (&rx_o[W-1:0]);
  assign flags_o.par_ok   = rx_en_ni | (^rx_o);
endmodule

// File: rtl/arb_drive.sv
module arb_drive #(
  parameter int unsigned W = 8
) (
  input  logic         cmp_ni,
  input  logic [W:0]   num_i,
  input  logic [W-1:0] rx_i,
  output logic [W:0]   pull_o
);
  logic lost;

  // MSB first: a loss at any higher position silences the bits below it
  always_comb begin
    lost = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      pull_o[i] = ~cmp_ni & num_i[i] & ~lost;
      lost      = lost | (rx_i[i] & ~num_i[i]);
    end
    pull_o[W] = ~cmp_ni & num_i[W] & ~lost;
  end
endmodule

// File: rtl/arb_judge.sv
module arb_judge #(
  parameter int unsigned W = 8
) (
  input  logic         cmp_ni,
  input  logic         rx_en_ni,
  input  logic         settle_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] rx_i,
  output logic         win_no
);
  logic eq, gt, hit;

  always_comb begin
    eq = 1'b1;
    gt = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      gt = gt | (eq & num_i[i] & ~rx_i[i]);
      eq = eq & ~(num_i[i] ^ rx_i[i]);
    end
    hit    = cmp_ni ? gt : eq;
    win_no = ~(settle_i & ~rx_en_ni & hit);
  end
endmodule

// File: rtl/arb_compete.sv
module arb_compete #(
  parameter int unsigned W = arb_pkg::ARB_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] num_i,
  input  logic         num_par_i,
  input  logic         le_ni,
  input  logic         cmp_ni,
  input  logic         rx_en_ni,
  input  logic         settle_i,
  input  logic [W:0]   ab_level_i,
  output logic [W:0]   ab_pull_o,
  output logic         win_no,
  output logic         all_ones_o,
  output logic         par_err_no
);
  localparam int unsigned FW = W + 1;

  logic [FW-1:0]      num_eff;
  logic [FW-1:0]      rx;
  arb_pkg::rx_flags_t flags;

  arb_num_latch #(.W(W)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .le_ni (le_ni),
    .num_i (num_i),
    .par_i (num_par_i),
    .num_o (num_eff)
  );

  arb_rx #(.W(W)) u_rx (
    .rx_en_ni(rx_en_ni),
    .level_i (ab_level_i),
    .rx_o    (rx),
    .flags_o (flags)
  );

  arb_drive #(.W(W)) u_drive (
    .cmp_ni(cmp_ni),
    .num_i (num_eff),
    .rx_i  (rx[W-1:0]),
    .pull_o(ab_pull_o)
  );

  arb_judge #(.W(W)) u_judge (
    .cmp_ni  (cmp_ni),
    .rx_en_ni(rx_en_ni),
    .settle_i(settle_i),
    .num_i   (num_eff[W-1:0]),
    .rx_i    (rx[W-1:0]),
    .win_no  (win_no)
  );

  assign all_ones_o = flags.all_ones;
  assign par_err_no = flags.par_ok;
endmodule

// File: rtl/arb_compete_chk.sv
module arb_compete_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         le_ni,
  input logic         cmp_ni,
  input logic         rx_en_ni,
  input logic         settle_i,
  input logic [W:0]   ab_level_i,
  input logic [W:0]   ab_pull_o,
  input logic         win_no,
  input logic         all_ones_o,
  input logic         par_err_no,
  input logic [W:0]   num_eff_i
);
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_ni && $past(!le_ni)) |-> $stable(num_eff_i));

  p_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_ni |-> (ab_pull_o == '0));

  p_own_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ab_pull_o & ~num_eff_i) == '0);

  p_win_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_ni && !rx_en_ni && settle_i && !win_no)
      |-> ((~ab_level_i[W-1:0]) == ab_pull_o[W-1:0]));

  p_all_ones_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_ni && ab_level_i[W-1:0] == '0) |-> all_ones_o);

  p_rx_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en_ni |-> (win_no && par_err_no && !all_ones_o));

  p_no_settle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !settle_i |-> win_no);
endmodule

bind arb_compete arb_compete_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .le_ni     (le_ni),
  .cmp_ni    (cmp_ni),
  .rx_en_ni  (rx_en_ni),
  .settle_i  (settle_i),
  .ab_level_i(ab_level_i),
  .ab_pull_o (ab_pull_o),
  .win_no    (win_no),
  .all_ones_o(all_ones_o),
  .par_err_no(par_err_no),
  .num_eff_i (num_eff)
);

// File: tb/arb_compete_test.sv
`timescale 1ns/1ps
module arb_compete_test;
  localparam int NM = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic settle;
  logic [7:0] num     [NM];
  logic       par     [NM];
  logic       le_n    [NM];
  logic       cmp_n   [NM];
  logic       rx_en_n [NM];
  logic [8:0] pull    [NM];
  logic       win_n   [NM];
  logic       all1    [NM];
  logic       perr    [NM];
  logic [8:0] level;
  logic [8:0] or_all;
  logic       ovr;
  logic [8:0] ovr_lvl;
  logic [7:0] cap  [NM];
  logic       capp [NM];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  arb_compete #(.W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .num_i(num[0]), .num_par_i(par[0]),
    .le_ni(le_n[0]), .cmp_ni(cmp_n[0]), .rx_en_ni(rx_en_n[0]),
    .settle_i(settle), .ab_level_i(level), .ab_pull_o(pull[0]),
    .win_no(win_n[0]), .all_ones_o(all1[0]), .par_err_no(perr[0])
  );

  for (genvar k = 1; k < NM; k++) begin : g_peer
    arb_compete #(.W(8)) peer (
      .clk_i(clk), .rst_ni(rst_n), .num_i(num[k]), .num_par_i(par[k]),
      .le_ni(le_n[k]), .cmp_ni(cmp_n[k]), .rx_en_ni(rx_en_n[k]),
      .settle_i(settle), .ab_level_i(level), .ab_pull_o(pull[k]),
      .win_no(win_n[k]), .all_ones_o(all1[k]), .par_err_no(perr[k])
    );
  end

  // wired-OR resolved once per clock; level low = asserted
  always_comb begin
    or_all = '0;
    for (int k = 0; k < NM; k++) or_all = or_all | pull[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   level <= 9'h1FF;
    else if (ovr) level <= ovr_lvl;
    else          level <= ~or_all;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_win(input bit competing, input logic [7:0] n,
                                 input logic [7:0] m);
    return competing ? (n == m) : (n > m);
  endfunction

  task automatic do_round(input int r, input bit force_ff, input bit none);
    int ff_idx;
    logic [7:0] m;
    logic wp;
    bit any;
    ff_idx = r % NM;
    @(negedge clk);
    settle = 1'b0;
    for (int k = 0; k < NM; k++) begin
      logic [7:0] v;
      bit dup;
      cmp_n[k] = none ? 1'b1 : ($urandom_range(0, 3) == 0);
      do begin
        v = 8'($urandom_range(0, 255));
        dup = 0;
        for (int j = 0; j < k; j++) if (cap[j] == v) dup = 1;
        if (force_ff && v == 8'hFF) dup = 1;
        if (force_ff && k == ff_idx) begin v = 8'hFF; dup = 0; end
      end while (dup);
      cap[k]  = v;
      capp[k] = ~(^v) ^ ($urandom_range(0, 7) == 0);
      num[k]  = v;
      par[k]  = capp[k];
      le_n[k] = 1'b1;
      rx_en_n[k] = 1'b0;
    end
    if (force_ff) cmp_n[ff_idx] = 1'b0;
    @(negedge clk);
    for (int k = 0; k < NM; k++) begin
      le_n[k] = 1'b0;
      num[k]  = 8'($urandom_range(0, 255));
      par[k]  = 1'($urandom_range(0, 1));
    end
    repeat (12) @(negedge clk);
    m = '0; wp = 1'b0; any = 0;
    for (int k = 0; k < NM; k++) begin
      if (!cmp_n[k] && (!any || cap[k] > m)) begin
        m = cap[k]; wp = capp[k]; any = 1;
      end
    end
    #1;
    chk(~level == {wp, m}, "R5", "settled bus", 32'(~level), 32'({wp, m}));
    chk(win_n[0] == 1'b1, "R11", "win while unsettled", 32'(win_n[0]), 32'd1);
    settle = 1'b1;
    #1;
    for (int k = 0; k < NM; k++) begin
      logic e;
      e = ~exp_win(!cmp_n[k], cap[k], m);
      chk(win_n[k] == e, cmp_n[k] ? "R7" : "R6", "win/greater flag",
          32'(win_n[k]), 32'(e));
    end
    chk(all1[0] == (m == 8'hFF), "R8", "all ones", 32'(all1[0]),
        32'(m == 8'hFF));
    chk(perr[0] == ^{wp, m}, "R9", "parity flag", 32'(perr[0]),
        32'(^{wp, m}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; settle = 1'b0; ovr = 1'b1; ovr_lvl = 9'h1FF;
    for (int k = 0; k < NM; k++) begin
      num[k] = '0; par[k] = 1'b0; le_n[k] = 1'b0; cmp_n[k] = 1'b1;
      rx_en_n[k] = 1'b0; cap[k] = '0; capp[k] = 1'b0;
    end
    cmp_n[0] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(pull[0] == 9'h000, "R1", "reset clears held number", 32'(pull[0]), 0);
    chk(win_n[0] == 1'b1, "R11", "win after reset", 32'(win_n[0]), 1);

    // R1 transparent then held
    @(negedge clk);
    num[0] = 8'hA5; par[0] = 1'b1; le_n[0] = 1'b1; #1;
    chk(pull[0] == 9'h1A5, "R1", "transparent drive", 32'(pull[0]), 32'h1A5);
    @(negedge clk);
    le_n[0] = 1'b0; num[0] = 8'h3C; par[0] = 1'b0; #1;
    chk(pull[0] == 9'h1A5, "R1", "held drive", 32'(pull[0]), 32'h1A5);
    cmp_n[0] = 1'b1; #1;
    chk(pull[0] == 9'h000, "R3", "idle drive", 32'(pull[0]), 0);
    cmp_n[0] = 1'b0;

    // R4 withdrawal, own number 0x5A parity 1
    @(negedge clk);
    num[0] = 8'h5A; par[0] = 1'b1; le_n[0] = 1'b1; ovr_lvl = ~9'h020;
    @(negedge clk); #1;
    chk(pull[0] == 9'h040, "R4", "withdraw below bit5", 32'(pull[0]), 32'h040);
    ovr_lvl = ~9'h0A0;
    @(negedge clk); #1;
    chk(pull[0] == 9'h000, "R4", "withdraw below bit7", 32'(pull[0]), 0);
    ovr_lvl = ~9'h15A;
    @(negedge clk); #1;
    chk(pull[0] == 9'h15A, "R4", "match keeps parity", 32'(pull[0]), 32'h15A);

    // R2 inversion, R8, R9
    ovr_lvl = 9'h000;
    @(negedge clk); #1;
    chk(all1[0] == 1'b1, "R2", "low level is asserted", 32'(all1[0]), 1);
    chk(perr[0] == 1'b1, "R9", "nine ones odd", 32'(perr[0]), 1);
    ovr_lvl = 9'h100;
    @(negedge clk); #1;
    chk(perr[0] == 1'b0, "R9", "eight ones even", 32'(perr[0]), 0);
    chk(all1[0] == 1'b1, "R8", "all ones no parity", 32'(all1[0]), 1);
    ovr_lvl = ~9'h17F;
    @(negedge clk); #1;
    chk(all1[0] == 1'b0, "R8", "bit7 clear", 32'(all1[0]), 0);

    // R6 / R7 directed
    settle = 1'b1; ovr_lvl = ~9'h15A;
    @(negedge clk); #1;
    chk(win_n[0] == 1'b0, "R6", "equal wins", 32'(win_n[0]), 0);
    ovr_lvl = ~9'h15B;
    @(negedge clk); #1;
    chk(win_n[0] == 1'b1, "R6", "unequal loses", 32'(win_n[0]), 1);
    cmp_n[0] = 1'b1; ovr_lvl = ~9'h159;
    @(negedge clk); #1;
    chk(win_n[0] == 1'b0, "R7", "greater than winner", 32'(win_n[0]), 0);
    ovr_lvl = ~9'h15A;
    @(negedge clk); #1;
    chk(win_n[0] == 1'b1, "R7", "equal is not greater", 32'(win_n[0]), 1);

    // R10 receivers off
    cmp_n[0] = 1'b0; rx_en_n[0] = 1'b1; ovr_lvl = ~9'h180;
    @(negedge clk); #1;
    chk(pull[0] == 9'h15A, "R10", "no withdrawal", 32'(pull[0]), 32'h15A);
    chk(win_n[0] == 1'b1, "R10", "win off", 32'(win_n[0]), 1);
    chk(perr[0] == 1'b1, "R10", "parity flag off", 32'(perr[0]), 1);
    ovr_lvl = 9'h000;
    @(negedge clk); #1;
    chk(all1[0] == 1'b0, "R10", "all ones off", 32'(all1[0]), 0);
    rx_en_n[0] = 1'b0; settle = 1'b0;

    // bus resolved from modules
    ovr = 1'b0;
    do_round(0, 1'b0, 1'b1);
    do_round(1, 1'b1, 1'b0);
    do_round(6, 1'b1, 1'b0);
    for (int r = 0; r < 300; r++) do_round(r, 1'b0, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule